// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address-Wake Filtering

This block is the receive half of an asynchronous serial port. A serial line is brought in through a two-flop synchroniser and sampled on an oversampling tick, sixteen ticks per bit. A falling edge starts a frame, which the block confirms half a bit later. Each data bit is then taken at its middle sample, least significant bit first. The frame carries eight data bits and one optional extra bit. The extra bit is either a parity bit or a ninth data bit. A finished character is loaded into a receive buffer and raises a ready flag. That flag drops when the buffer is read.

Errors are kept as sticky flags in a status byte: parity mismatch, a missing stop bit, overrun of an unread buffer, and line break. A read strobe on the status byte clears them. An error summary bit reflects any of the first three. For multi-drop links there is an address-wake mode, set by a pulse. While the mode is on, every nine-bit frame whose ninth bit is 0 is dropped. The first frame whose ninth bit is 1 is loaded, and the hardware then turns the mode off.

Top module: `uart_rx_attn`

## Requirements
- R1: After reset the status byte, the receive buffer, the ready flag and the address-wake flag are all 0.
- R2: A frame has a start bit, data bits sent least significant bit first, an optional extra bit and a stop bit. When the frame completes, the data is loaded into the buffer and the ready flag rises. A buffer read strobe clears the ready flag.
- R3: In nine-bit mode the extra bit is the ninth data bit and is shown in status bit 5. No parity bit is expected, and the parity enable input has no effect.
- R4: In eight-bit mode with parity enabled, the extra bit is a parity bit. The check is even parity by default and odd parity when the odd-select input is 1. A mismatch sets status bit 0.
- R5: A low level at the stop-bit sample sets status bit 1.
- R6: A character that loads while the ready flag is still set, with no buffer read in the same cycle, sets status bit 2. The new data replaces the old.
- R7: A status read strobe clears bits 0, 1, 2 and 4. Bit 3 is 1 exactly while any of bits 0 to 2 is 1.
- R8: A frame whose data and extra bits are all 0 and whose stop bit is low sets status bit 4.
- R9: While address-wake is on, frames whose ninth bit is 0 do not load the buffer and do not raise the ready flag or any error flag. A frame whose ninth bit is 1 loads normally and clears address-wake.
- R10: A low pulse shorter than half a bit on an idle line does not start a frame.
- R11: Status bit 6 follows the transmit-active input, and bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rxIn | input | 1 | Serial line, idles high |
| baudTick | input | 1 | Oversampling tick, 16 per bit |
| cfgNineBits | input | 1 | 1 selects nine data bits |
| cfgParityEn | input | 1 | Enables parity in eight-bit mode |
| cfgParityOdd | input | 1 | 1 selects odd parity |
| attnSet | input | 1 | Pulse that turns on address-wake |
| txActive | input | 1 | Transmitter busy, shown in status bit 6 |
| bufRd | input | 1 | Receive buffer read strobe |
| statRd | input | 1 | Status read strobe |
| rxData | output | 8 | Receive buffer |
| rxReady | output | 1 | Buffer holds an unread character |
| attnActive | output | 1 | Address-wake is on |
| statusByte | output | 8 | Status: bit0 parity, bit1 framing, bit2 overrun, bit3 any error, bit4 break, bit5 ninth bit, bit6 transmit active, bit7 zero |

## Verification
The bench looks for these corner cases and the failure each one would expose:
- A short low glitch on the idle line. A receiver that does not confirm the start bit would load a garbage character.
- A second character arriving before the first is read. A design without overrun tracking would overwrite the buffer silently.
- Address-wake with a data frame followed by an address frame. A faulty filter either loads the data frame or leaves the mode set after the address frame.
- Nine-bit frames sent with parity enabled and an all-zero frame with a low stop bit. These catch a parity check that is wrongly applied and a break that is reported as a plain framing error.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic sampleVal;
    logic shiftData;
    logic takeExtra;
    logic frameDone;
    logic stopLow;
  } rxStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_EXTRA,
    ST_STOP,
    ST_WAITHI
  } rxState_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxIn,
  input  logic       baudTick,
  input  logic       cfgNineBits,
  input  logic       cfgParityEn,
  output rxStrobes_t strobes
);

  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [1:0]       syncQ;
  logic             rxS;
  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             atBitMid;
  logic             hasExtra;

  // two-flop synchroniser, idles high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= 2'b11;
    else        syncQ <= {syncQ[0], rxIn};
  end
  assign rxS = syncQ[1];

  assign hasExtra = cfgNineBits | cfgParityEn;
  assign atBitMid = baudTick && (tickCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (baudTick) begin
      case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          bitCnt  <= '0;
          if (!rxS) state <= ST_START;
        end
        ST_START: begin
          if (tickCnt == MID_CNT) begin
            tickCnt <= '0;
            state   <= rxS ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            if (bitCnt == LAST_BIT) begin
              bitCnt <= '0;
              state  <= hasExtra ? ST_EXTRA : ST_STOP;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_EXTRA: begin
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            state   <= ST_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            state   <= rxS ? ST_IDLE : ST_WAITHI;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_WAITHI: begin
          tickCnt <= '0;
          if (rxS) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.sampleVal = rxS;
    strobes.shiftData = (state == ST_DATA)  && atBitMid;
    strobes.takeExtra = (state == ST_EXTRA) && atBitMid;
    strobes.frameDone = (state == ST_STOP)  && atBitMid;
    strobes.stopLow   = (state == ST_STOP)  && atBitMid && !rxS;
  end

  // checker counter: data shifts seen since the frame began
  logic [BIT_W:0] shiftSeen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  shiftSeen <= '0;
    else if (state == ST_IDLE)   shiftSeen <= '0;
    else if (strobes.shiftData)  shiftSeen <= shiftSeen + 1'b1;
  end

  assert_bit_count_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    strobes.frameDone |-> (shiftSeen == (BIT_W+1)'(DATA_W)));

  assert_glitch_reject_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && baudTick && tickCnt == MID_CNT && rxS) |=> (state == ST_IDLE));

endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rxStrobes_t        strobes,
  input  logic              cfgNineBits,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              attnSet,
  input  logic              bufRd,
  input  logic              statRd,
  output logic [DATA_W-1:0] rxBuf,
  output logic              ninthQ,
  output logic              rxReady,
  output logic              peFlag,
  output logic              feFlag,
  output logic              doeFlag,
  output logic              bkdFlag,
  output logic              attnEn
);

  logic [DATA_W-1:0] shiftQ;
  logic              extraQ;
  logic              extraUsed;
  logic              ninthRx;
  logic              accept;
  logic              parityBad;
  logic              zeroFrame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftQ <= '0;
      extraQ <= 1'b0;
    end else begin
      if (strobes.shiftData) shiftQ <= {strobes.sampleVal, shiftQ[DATA_W-1:1]};
      if (strobes.takeExtra) extraQ <= strobes.sampleVal;
    end
  end

  assign extraUsed = cfgNineBits | cfgParityEn;
  assign ninthRx   = cfgNineBits & extraQ;
  assign accept    = strobes.frameDone && !(attnEn && !ninthRx);
  assign parityBad = cfgParityEn && !cfgNineBits && ((^shiftQ) ^ extraQ ^ cfgParityOdd);
  assign zeroFrame = (shiftQ == '0) && !(extraUsed && extraQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxBuf   <= '0;
      ninthQ  <= 1'b0;
      rxReady <= 1'b0;
      peFlag  <= 1'b0;
      feFlag  <= 1'b0;
      doeFlag <= 1'b0;
      bkdFlag <= 1'b0;
      attnEn  <= 1'b0;
    end else begin
      if (accept) begin
        rxBuf  <= shiftQ;
        ninthQ <= ninthRx;
      end

      if (accept)     rxReady <= 1'b1;
      else if (bufRd) rxReady <= 1'b0;

      if (accept && parityBad)                  peFlag  <= 1'b1;
      else if (statRd)                          peFlag  <= 1'b0;
      if (accept && strobes.stopLow)            feFlag  <= 1'b1;
      else if (statRd)                          feFlag  <= 1'b0;
      if (accept && rxReady && !bufRd)          doeFlag <= 1'b1;
      else if (statRd)                          doeFlag <= 1'b0;
      if (accept && strobes.stopLow && zeroFrame) bkdFlag <= 1'b1;
      else if (statRd)                          bkdFlag <= 1'b0;

      if (accept && ninthRx) attnEn <= 1'b0;
      else if (attnSet)      attnEn <= 1'b1;
    end
  end

  assert_ready_load_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxReady) |-> $past(strobes.frameDone));

  assert_no_overflow_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doeFlag) |-> $past(rxReady && !bufRd));

  assert_attn_discard_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.frameDone && attnEn && !(cfgNineBits && extraQ)) |=> $stable(rxBuf));

  assert_attn_clear_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.frameDone && cfgNineBits && extraQ) |=> !attnEn);

  assert_stat_clear_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (statRd && !strobes.frameDone) |=> !(peFlag || feFlag || doeFlag || bkdFlag));

  assert_nine_no_parity_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.frameDone && cfgNineBits && !statRd) |=> $stable(peFlag));

endmodule

// File: rtl/uart_rx_attn.sv
module uart_rx_attn
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxIn,
  input  logic              baudTick,
  input  logic              cfgNineBits,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              attnSet,
  input  logic              txActive,
  input  logic              bufRd,
  input  logic              statRd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              attnActive,
  output logic [7:0]        statusByte
);

  rxStrobes_t strobes;
  logic peFlag, feFlag, doeFlag, bkdFlag, ninthQ;

  uart_rx_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxIn       (rxIn),
    .baudTick   (baudTick),
    .cfgNineBits(cfgNineBits),
    .cfgParityEn(cfgParityEn),
    .strobes    (strobes)
  );

  uart_rx_dp #(.DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .cfgNineBits (cfgNineBits),
    .cfgParityEn (cfgParityEn),
    .cfgParityOdd(cfgParityOdd),
    .attnSet     (attnSet),
    .bufRd       (bufRd),
    .statRd      (statRd),
    .rxBuf       (rxData),
    .ninthQ      (ninthQ),
    .rxReady     (rxReady),
    .peFlag      (peFlag),
    .feFlag      (feFlag),
    .doeFlag     (doeFlag),
    .bkdFlag     (bkdFlag),
    .attnEn      (attnActive)
  );

  assign statusByte = {1'b0, txActive, ninthQ, bkdFlag,
                       (peFlag | feFlag | doeFlag), doeFlag, feFlag, peFlag};

endmodule

// File: tb/uart_rx_attn_tb.sv
module uart_rx_attn_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxIn = 1'b1;
  logic       baudTick;
  logic       cfgNineBits = 1'b0;
  logic       cfgParityEn = 1'b0;
  logic       cfgParityOdd = 1'b0;
  logic       attnSet = 1'b0;
  logic       txActive = 1'b0;
  logic       bufRd = 1'b0;
  logic       statRd = 1'b0;
  logic [7:0] rxData;
  logic       rxReady;
  logic       attnActive;
  logic [7:0] statusByte;
  logic [1:0] tickDiv;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) begin
    if (!rst_n) tickDiv <= 2'd0;
    else        tickDiv <= tickDiv + 2'd1;
  end
  assign baudTick = (tickDiv == 2'd3);

  uart_rx_attn dut_i (
    .clk(clk), .rst_n(rst_n), .rxIn(rxIn), .baudTick(baudTick),
    .cfgNineBits(cfgNineBits), .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd),
    .attnSet(attnSet), .txActive(txActive), .bufRd(bufRd), .statRd(statRd),
    .rxData(rxData), .rxReady(rxReady), .attnActive(attnActive), .statusByte(statusByte)
  );

  typedef struct packed {
    logic       nine;
    logic       parEn;
    logic       odd;
    logic [8:0] payload;
    logic       parFlip;
    logic       stopLow;
    logic [7:0] expStatus;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b0, 8'h00},  // R2 plain byte
    '{1'b0, 1'b1, 1'b0, 9'h03C, 1'b0, 1'b0, 8'h00},  // R4 even parity good
    '{1'b0, 1'b1, 1'b0, 9'h03C, 1'b1, 1'b0, 8'h09},  // R4 even parity bad
    '{1'b0, 1'b1, 1'b1, 9'h001, 1'b0, 1'b0, 8'h00},  // R4 odd parity good
    '{1'b0, 1'b0, 1'b0, 9'h07E, 1'b0, 1'b1, 8'h0A},  // R5 low stop
    '{1'b1, 1'b1, 1'b0, 9'h181, 1'b0, 1'b0, 8'h20},  // R3 ninth=1, parity ignored
    '{1'b1, 1'b0, 1'b0, 9'h0FF, 1'b0, 1'b0, 8'h00},  // R3 ninth=0
    '{1'b0, 1'b0, 1'b0, 9'h000, 1'b0, 1'b1, 8'h1A}   // R8 break
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic v);
    rxIn = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] data, input logic hasExtra,
                           input logic extraVal, input logic stopVal);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(data[i]);
    if (hasExtra) sendBit(extraVal);
    sendBit(stopVal);
    sendBit(1'b1);
  endtask

  task automatic pulseStat();
    statRd = 1'b1; @(negedge clk); statRd = 1'b0; @(negedge clk);
  endtask

  task automatic pulseBuf();
    bufRd = 1'b1; @(negedge clk); bufRd = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    // R1 reset state
    check("R1 status", {8'h0, statusByte}, 16'h0000);
    check("R1 ready", {15'h0, rxReady}, 16'h0000);
    check("R1 data", {8'h0, rxData}, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 attn", {15'h0, attnActive}, 16'h0000);

    // vector table walk: R2 R3 R4 R5 R8 R7
    for (int v = 0; v < NVEC; v++) begin
      logic ext;
      cfgNineBits  = VECS[v].nine;
      cfgParityEn  = VECS[v].parEn;
      cfgParityOdd = VECS[v].odd;
      if (VECS[v].nine) ext = VECS[v].payload[8];
      else ext = (VECS[v].odd ? ~^VECS[v].payload[7:0] : ^VECS[v].payload[7:0]) ^ VECS[v].parFlip;
      sendFrame(VECS[v].payload[7:0], VECS[v].nine | VECS[v].parEn, ext, ~VECS[v].stopLow);
      check($sformatf("R2 vec%0d ready", v), {15'h0, rxReady}, 16'h0001);
      check($sformatf("R2 vec%0d data", v), {8'h0, rxData}, {8'h0, VECS[v].payload[7:0]});
      check($sformatf("R3/R4/R5/R8 vec%0d status", v), {8'h0, statusByte}, {8'h0, VECS[v].expStatus});
      pulseStat();
      check($sformatf("R7 vec%0d cleared", v), {8'h0, statusByte & 8'h1F}, 16'h0000);
      pulseBuf();
      check($sformatf("R2 vec%0d ready clear", v), {15'h0, rxReady}, 16'h0000);
    end
    cfgNineBits = 1'b0; cfgParityEn = 1'b0; cfgParityOdd = 1'b0;

    // R11 transmit-active mirror, bit 7 zero
    txActive = 1'b1; @(negedge clk);
    check("R11 tx bit", {8'h0, statusByte}, 16'h0040);
    txActive = 1'b0; @(negedge clk);

    // R10 short glitch rejected
    rxIn = 1'b0; repeat (16) @(negedge clk);
    rxIn = 1'b1; repeat (300) @(negedge clk);
    check("R10 glitch no load", {15'h0, rxReady}, 16'h0000);
    sendFrame(8'h5A, 1'b0, 1'b0, 1'b1);
    check("R10 frame after glitch", {8'h0, rxData}, 16'h005A);
    pulseBuf();

    // R6 overrun
    sendFrame(8'h11, 1'b0, 1'b0, 1'b1);
    sendFrame(8'h22, 1'b0, 1'b0, 1'b1);
    check("R6 overrun status", {8'h0, statusByte}, 16'h000C);
    check("R6 newest data", {8'h0, rxData}, 16'h0022);
    pulseStat();
    check("R7 summary drops", {8'h0, statusByte}, 16'h0000);
    pulseBuf();

    // R9 address-wake
    cfgNineBits = 1'b1;
    attnSet = 1'b1; @(negedge clk); attnSet = 1'b0; @(negedge clk);
    check("R9 attn on", {15'h0, attnActive}, 16'h0001);
    sendFrame(8'h55, 1'b1, 1'b0, 1'b1);
    check("R9 data frame dropped", {15'h0, rxReady}, 16'h0000);
    check("R9 buffer kept", {8'h0, rxData}, 16'h0022);
    check("R9 attn still on", {15'h0, attnActive}, 16'h0001);
    sendFrame(8'h12, 1'b1, 1'b1, 1'b1);
    check("R9 address loads", {7'h0, rxReady, rxData}, 16'h0112);
    check("R9 address status", {8'h0, statusByte}, 16'h0020);
    check("R9 attn cleared", {15'h0, attnActive}, 16'h0000);
    pulseBuf();
    sendFrame(8'h34, 1'b1, 1'b0, 1'b1);
    check("R9 normal after wake", {7'h0, rxReady, rxData}, 16'h0134);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule